// File: doc/BRIEF.md
# Burst-Mode TCM Line Transmitter

This block is the transmit half of the timing-master end of a two-wire digital subscriber line that carries two 8-bit bearer channels and one 2-bit signalling channel per 8 kHz frame. Because the line runs in both directions over one pair, traffic is sent in compressed bursts. The block keeps the two most recent frames. When a burst-start strobe arrives (once every 250 us, derived from the 4.096 MHz master clock), it sends the 36 bits of those two frames as one burst at the line symbol rate, which a one-cycle symbol enable sets.

A burst opens with a framing mark that is never scrambled. It is followed by the 36 payload bits, each passed through a self-synchronizing scrambler with polynomial x^9 + x^5 + 1. Every symbol is line-coded as alternate mark inversion. The output is a ternary symbol on two wires, and each symbol is held until the next enable. A receive-inhibit output tells the local receiver to ignore the line while the burst is being driven. The scrambler register and the mark polarity carry over from one burst to the next, so the framing mark always takes the polarity opposite to the last mark of the previous burst.

Top module: `tcm_burst_tx`

## Requirements
- R1: A synchronous reset (`rst` high) sets the line output to zero (`txPos`=0, `txNeg`=0), sets `rxInhibit` low, clears the scrambler to all zeros and makes the next mark positive.
- R2: A pulse on `frameLoad` captures the frame {`b1`,`b2`,`dch`}. The burst carries the two most recently captured frames, the earlier one first, and inside each frame B1, then B2, then D, most significant bit first. A frame captured in the same cycle as an accepted burst start goes into the following burst.
- R3: A `burstStart` pulse seen while no burst is running starts a burst. The burst takes exactly 37 symbols on the next 37 `symEn` pulses. A `burstStart` that arrives while a burst is running, including in the cycle of its last symbol, has no effect.
- R4: The first symbol of each burst is always a mark, bypasses the scrambler and does not advance it.
- R5: Each payload bit d is sent as s = d XOR stage5 XOR stage9, and s is then shifted into the scrambler (stage1 takes the newest bit, stage9 the oldest).
- R6: Symbol encoding: zero = {`txPos`,`txNeg`}=00, positive mark = 10, negative mark = 01. A 0 bit is zero, and every mark, the framing mark included, has the opposite polarity to the mark before it.
- R7: `rxInhibit` rises in the cycle after an accepted `burstStart`. It falls in the cycle after the first `symEn` that follows the last symbol of the burst, so it spans 38 `symEn` pulses for an isolated burst.
- R8: A `symEn` that arrives while no burst is running drives a zero symbol. The scrambler register and the polarity carry over unchanged between bursts.
- R9: The line symbol changes only in the cycle after a `symEn` pulse, or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4.096 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| symEn | input | 1 | One-cycle line symbol enable |
| burstStart | input | 1 | One-cycle strobe, once per 250 us burst period |
| frameLoad | input | 1 | Captures one 8 kHz frame from b1, b2, dch |
| b1 | input | 8 | First bearer channel octet |
| b2 | input | 8 | Second bearer channel octet |
| dch | input | 2 | Signalling channel bits for the frame |
| txPos | output | 1 | Positive mark on the line |
| txNeg | output | 1 | Negative mark on the line |
| rxInhibit | output | 1 | Local receiver must ignore the line |

## Verification
The hardest situations to reach from the ports are the collisions at a burst's edges. These are a burst start in the same cycle as the last symbol enable, a burst start in the same cycle as a symbol enable, a frame capture in the same cycle as a burst start, and a second burst that begins before the inhibit has dropped from the first. The stimulus lines these up on purpose. It holds a train of burst-start pulses across the end of one burst, so the last ignored pulse and the first accepted pulse fall on adjacent cycles. It then resets in mid-burst to show that the scrambler and the polarity restart. A behavioural model checks every cycle, and the bench also descrambles the line to recover each burst's payload. It counts the symbol enables under the inhibit, weighted by the number of bursts the model accepted in that window.

// File: rtl/tcm_tx_pkg.sv
`timescale 1ns/1ps
package tcm_tx_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadPayload;  // latch the two stored frames into the burst shifter
    logic emitStart;    // drive the framing mark on this symbol
    logic emitData;     // drive the next scrambled payload bit
    logic emitIdle;     // symbol slot outside a burst: drive zero
  } tx_strobe_t;

  localparam int FRAMES_PER_BURST = 2;
endpackage

// File: rtl/tcm_tx_ctrl.sv
`timescale 1ns/1ps
module tcm_tx_ctrl
  import tcm_tx_pkg::*;
#(
  parameter int PAYLOAD_BITS = 36
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       symEn,
  input  logic       burstStart,
  output tx_strobe_t strobe,
  output logic       rxInhibit
);
  localparam int SYMS  = PAYLOAD_BITS + 1;
  localparam int CNT_W = $clog2(SYMS);

  logic             busy;
  logic             symActive;
  logic [CNT_W-1:0] cnt;
  logic             lastSym;

  assign lastSym = (cnt == CNT_W'(SYMS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      symActive <= 1'b0;
      cnt       <= '0;
    end else begin
      if (symEn) symActive <= busy;
      if (busy && symEn) begin
        cnt <= cnt + 1'b1;
        if (lastSym) busy <= 1'b0;
      end else if (!busy && burstStart) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end

  always_comb begin
    strobe.loadPayload = burstStart && !busy;
    strobe.emitStart   = symEn && busy && (cnt == '0);
    strobe.emitData    = symEn && busy && (cnt != '0);
    strobe.emitIdle    = symEn && !busy;
  end

  assign rxInhibit = busy || symActive;

  // R3: a burst ends only on the enable of its last symbol
  assert_burst_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(symEn) && $past(cnt) == CNT_W'(SYMS - 1)));

  // R3: a start strobe during a burst leaves the sequence untouched
  assert_ignore_start_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && burstStart && !symEn) |=> (busy && $stable(cnt)));

  // R7: the inhibit is released only on a symbol enable
  assert_inhibit_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rxInhibit) |-> $past(symEn));
endmodule

// File: rtl/tcm_tx_datapath.sv
`timescale 1ns/1ps
module tcm_tx_datapath
  import tcm_tx_pkg::*;
#(
  parameter int B_BITS  = 8,
  parameter int D_BITS  = 2,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameLoad,
  input  logic [B_BITS-1:0] b1,
  input  logic [B_BITS-1:0] b2,
  input  logic [D_BITS-1:0] dch,
  input  tx_strobe_t        strobe,
  output logic              txPos,
  output logic              txNeg
);
  localparam int FRAME_BITS   = 2 * B_BITS + D_BITS;
  localparam int PAYLOAD_BITS = FRAMES_PER_BURST * FRAME_BITS;

  logic [FRAME_BITS-1:0]   olderFrame, newerFrame;
  logic [PAYLOAD_BITS-1:0] shifter;
  logic [SCR_LEN-1:0]      scr;      // scr[0] = stage 1 (newest)
  logic                    lastPos;  // polarity of the last mark sent
  logic                    scrOut;
  logic                    markBit;
  logic                    emitAny;

  assign scrOut  = shifter[PAYLOAD_BITS-1] ^ scr[SCR_TAP-1] ^ scr[SCR_LEN-1];
  assign markBit = strobe.emitStart ? 1'b1 : scrOut;
  assign emitAny = strobe.emitStart || strobe.emitData;

  // Frame store: keep the two most recent frames
  always_ff @(posedge clk) begin
    if (rst) begin
      olderFrame <= '0;
      newerFrame <= '0;
    end else if (frameLoad) begin
      olderFrame <= newerFrame;
      newerFrame <= {b1, b2, dch};
    end
  end

  // Burst shifter and scrambler
  always_ff @(posedge clk) begin
    if (rst) begin
      shifter <= '0;
      scr     <= '0;
    end else if (strobe.loadPayload) begin
      shifter <= {olderFrame, newerFrame};
    end else if (strobe.emitData) begin
      shifter <= shifter << 1;
      scr     <= {scr[SCR_LEN-2:0], scrOut};
    end
  end

  // AMI line coder
  always_ff @(posedge clk) begin
    if (rst) begin
      txPos   <= 1'b0;
      txNeg   <= 1'b0;
      lastPos <= 1'b0;
    end else if (emitAny) begin
      if (markBit) begin
        txPos   <= !lastPos;
        txNeg   <= lastPos;
        lastPos <= !lastPos;
      end else begin
        txPos <= 1'b0;
        txNeg <= 1'b0;
      end
    end else if (strobe.emitIdle) begin
      txPos <= 1'b0;
      txNeg <= 1'b0;
    end
  end

  // R4: the framing mark is a mark and flips the polarity
  assert_start_mark_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.emitStart |=> ((txPos || txNeg) && lastPos != $past(lastPos)));

  // R4: the framing mark does not advance the scrambler
  assert_start_noscr_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.emitStart |=> $stable(scr));

  // R8: idle symbol slots drive zero and keep the polarity
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.emitIdle |=> (!txPos && !txNeg && $stable(lastPos)));

  // R9: the line holds between symbol enables
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(emitAny || strobe.emitIdle) |=> ($stable(txPos) && $stable(txNeg)));

  // R6: never both polarities at once
  assert_ternary_R6: assert property (@(posedge clk) disable iff (rst)
    !(txPos && txNeg));
endmodule

// File: rtl/tcm_burst_tx.sv
`timescale 1ns/1ps
module tcm_burst_tx
  import tcm_tx_pkg::*;
#(
  parameter int B_BITS  = 8,
  parameter int D_BITS  = 2,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              symEn,
  input  logic              burstStart,
  input  logic              frameLoad,
  input  logic [B_BITS-1:0] b1,
  input  logic [B_BITS-1:0] b2,
  input  logic [D_BITS-1:0] dch,
  output logic              txPos,
  output logic              txNeg,
  output logic              rxInhibit
);
  localparam int PAYLOAD_BITS = FRAMES_PER_BURST * (2 * B_BITS + D_BITS);

  tx_strobe_t strobe;

  tcm_tx_ctrl #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .symEn(symEn), .burstStart(burstStart),
    .strobe(strobe), .rxInhibit(rxInhibit)
  );

  tcm_tx_datapath #(
    .B_BITS(B_BITS), .D_BITS(D_BITS), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)
  ) u_dp (
    .clk(clk), .rst(rst), .frameLoad(frameLoad), .b1(b1), .b2(b2), .dch(dch),
    .strobe(strobe), .txPos(txPos), .txNeg(txNeg)
  );
endmodule

// File: tb/tb_tcm_burst_tx.sv
`timescale 1ns/1ps
module tb_tcm_burst_tx;
  localparam int NSYM  = 37;
  localparam int NDATA = 36;
  localparam int NCYC  = 1800;

  logic clk = 1'b0, rst = 1'b1, symEn = 1'b0, burstStart = 1'b0, frameLoad = 1'b0;
  logic [7:0] b1 = '0, b2 = '0;
  logic [1:0] dch = '0;
  logic txPos, txNeg, rxInhibit;

  int nChecks = 0, nFail = 0;

  tcm_burst_tx dut (
    .clk(clk), .rst(rst), .symEn(symEn), .burstStart(burstStart),
    .frameLoad(frameLoad), .b1(b1), .b2(b2), .dch(dch),
    .txPos(txPos), .txNeg(txNeg), .rxInhibit(rxInhibit)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mBusy = 0, mCnt = 0, mSymAct = 0, lastPol = -1, expSym = 0, expInh = 0;
  int mNewSym = 0, mIdx = 0, mAcc = 0;
  logic [17:0] fOld = '0, fNew = '0;
  bit payQ[$], scrH[$], expPay[$];
  string mPhase = "R1";

  always @(posedge clk) begin
    int oldBusy;
    bit d, s, mark, tmp;
    mNewSym = 0;
    if (rst) begin
      mBusy = 0; mCnt = 0; mSymAct = 0; lastPol = -1; expSym = 0; expInh = 0;
      fOld = '0; fNew = '0; payQ = {}; mPhase = "R1";
      scrH = {};
      for (int i = 0; i < 9; i++) scrH.push_back(1'b0);
    end else begin
      oldBusy = mBusy;
      if (symEn) begin
        mSymAct = oldBusy;
        if (oldBusy) begin
          mPhase = (mCnt == 0) ? "R4" : "R5";
          if (mCnt == 0) mark = 1'b1;
          else begin
            d = payQ.pop_front();
            s = d ^ scrH[4] ^ scrH[8];
            scrH.push_front(s);
            tmp = scrH.pop_back();
            mark = s;
          end
          if (mark) begin
            lastPol = -lastPol;
            expSym = lastPol;
          end else expSym = 0;
          mNewSym = 1; mIdx = mCnt;
          mCnt++;
          if (mCnt == NSYM) mBusy = 0;
        end else begin
          mPhase = "R8";
          expSym = 0;
        end
      end else mPhase = "R9";
      if (!oldBusy && burstStart) begin
        payQ = {};
        for (int i = 17; i >= 0; i--) payQ.push_back(fOld[i]);
        for (int i = 17; i >= 0; i--) payQ.push_back(fNew[i]);
        expPay = payQ;
        mBusy = 1; mCnt = 0; mAcc++;
      end
      if (frameLoad) begin
        fOld = fNew;
        fNew = {b1, b2, dch};
      end
      expInh = (mBusy != 0 || mSymAct != 0) ? 1 : 0;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  // ---------------- stimulus and checking ----------------
  bit dh[$], rxBits[$];
  int lastObs = -1, inhCnt = 0, prevInh = 0;

  task automatic clear_decoder();
    dh = {};
    for (int i = 0; i < 9; i++) dh.push_back(1'b0);
    rxBits = {};
    lastObs = -1;
  endtask

  function automatic bit is_burst_cycle(int c);
    return (c == 20 || c == 200 || c == 260 || c == 401 || c == 647 || c == 800 ||
            (c >= 940 && c <= 952) || c == 1250 || c == 1400 || c == 1600);
  endfunction

  initial begin
    clear_decoder();
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      // every-cycle comparison against the model
      if (c > 0) begin
        check(txPos === (expSym == 1) && txNeg === (expSym == -1), mPhase,
              "line symbol", {txPos, txNeg}, expSym);
        check(rxInhibit === (expInh != 0), "R7", "rxInhibit", rxInhibit, expInh);
      end
      if (c == 3) begin
        check(!txPos && !txNeg, "R1", "symbol in reset", {txPos, txNeg}, 0);
        check(!rxInhibit, "R1", "inhibit in reset", rxInhibit, 0);
      end
      // decode the line
      if (mNewSym != 0) begin
        bit mk, dd, tmp;
        int pol;
        mk  = txPos | txNeg;
        pol = txPos ? 1 : -1;
        if (mIdx == 0) check(mk, "R4", "framing mark present", mk, 1);
        if (mk) begin
          check(pol == -lastObs, (lastObs == -1 && mIdx == 0) ? "R1" : "R6",
                "mark polarity", pol, -lastObs);
          lastObs = pol;
        end
        if (mIdx > 0) begin
          dd = mk ^ dh[4] ^ dh[8];
          dh.push_front(mk);
          tmp = dh.pop_back();
          rxBits.push_back(dd);
        end
        if (mIdx == NSYM - 1) begin
          int bad = 0;
          for (int i = 0; i < NDATA; i++) if (rxBits[i] != expPay[i]) bad++;
          check(bad == 0 && rxBits.size() == NDATA, "R2",
                "descrambled payload mismatches", bad, 0);
          rxBits = {};
        end
      end
      // inhibit window length in symbol enables
      if (prevInh != 0 && symEn) inhCnt++;
      if (prevInh != 0 && !rxInhibit) begin
        if (!rst)
          check(inhCnt == NSYM * mAcc + 1, "R3", "enables under inhibit",
                inhCnt, NSYM * mAcc + 1);
        inhCnt = 0;
        mAcc = 0;
      end
      if (rst) begin
        inhCnt = 0;
        mAcc = 0;
      end
      prevInh = rxInhibit;
      // drive the next inputs
      rst        = (c < 4) || (c >= 1300 && c < 1303);
      if (rst) clear_decoder();
      symEn      = (c % 4 == 1);
      burstStart = is_burst_cycle(c);
      frameLoad  = (c % 80 == 7);
      if (frameLoad) begin
        b1  = 8'($urandom);
        b2  = 8'($urandom);
        dch = 2'($urandom);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule